// File: doc/BRIEF.md
# I2C Target with Clock-Stretching Data Buffer

This block is the target (slave) side of a two-wire serial bus. It runs on a fast system clock and watches the bus clock and data lines through synchronizers. It compares each address byte with a programmable 7-bit own address. When the address matches, it acknowledges and then either receives or transmits bytes. The direction bit at the end of the address byte decides which.

The host side sees one data register per direction. Each sits in front of a shift register. Flags tell the host that the block was addressed, that a received byte is waiting, that the transmit register has room, that a byte boundary is stalled, and that a write ended with STOP. Whenever the host falls behind, the block holds the bus clock low instead of losing or repeating data: after an address match, when a received byte cannot be handed over, or when there is nothing to send. The bus master then simply waits.

The bus pins are open-drain. The block only reports when it wants to pull a line low (`scl_oe`, `sda_oe`). The pad or the bench forms the wired-AND with the other devices.

Top module: `i2c_target`

## Requirements
- R1: After reset, neither bus line is pulled low, `addr_hit`, `rx_full`, `byte_done` and `stop_seen` are 0, and `tx_empty` is 1.
- R2: After a START, the upper seven bits of the first byte (sent MSB first) are compared with `own_addr`. On equality, SDA is pulled low for the whole ninth clock pulse. On inequality, there is no acknowledge, no flag changes, SCL is never held, and the rest of the transfer is ignored until the next START.
- R3: A match sets `addr_hit`. From the falling SCL edge that ends the acknowledge pulse, SCL is held low for as long as `addr_hit` stays set. `clr_addr` clears it, and the clear takes effect on the next cycle.
- R4: With the direction bit 0, data bits are sampled on rising SCL, MSB first, and every byte is acknowledged. `rx_full` rises only after the acknowledge pulse has ended, and `rx_data` then holds the byte. `rx_rd` clears `rx_full`.
- R5: If a byte completes while `rx_full` is still set, the byte is still acknowledged, `byte_done` is set and SCL is held low, and `rx_data` keeps the unread byte. After `rx_rd`, the waiting byte moves into `rx_data`, `rx_full` is set again, `byte_done` is cleared and SCL is released.
- R6: With the direction bit 1, `dir_tx` is 1 and bytes written through `tx_data`/`tx_wr` are sent MSB first. At the start of each byte, the register contents move into the shift register and `tx_empty` goes back to 1, so the next byte can be written while the current one is sent.
- R7: SCL is held low before a transmitted byte while no byte is available. If the master acknowledges a byte and the register is empty, `byte_done` is set. In all these cases, the byte sent after the next `tx_wr` is the newly written one, never a repeat. `tx_wr` clears `byte_done` and `tx_empty` on the next cycle.
- R8: After a master NACK (SDA high in the ninth pulse of a transmitted byte), SDA is released and not driven again until a new START.
- R9: A STOP (SDA rising while SCL is high) during an addressed receive sets `stop_seen` until `clr_stop`. A STOP that ends a transmit, or that follows an unmatched address, leaves `stop_seen` at 0.
- R10: `sda_oe` only changes while SCL is low.
- R11: A START without a preceding STOP (repeated START) begins a new address phase. It can change the direction within one bus ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_data | output | 8 | Last byte handed over from the bus |
| rx_rd | input | 1 | Read strobe, frees `rx_data` |
| clr_addr | input | 1 | Clears `addr_hit` |
| clr_stop | input | 1 | Clears `stop_seen` |
| addr_hit | output | 1 | Own address was acknowledged |
| dir_tx | output | 1 | Direction of the current transfer, 1 = target sends |
| rx_full | output | 1 | `rx_data` holds an unread byte |
| tx_empty | output | 1 | Transmit register may be written |
| byte_done | output | 1 | A byte boundary is stalled waiting for the host |
| stop_seen | output | 1 | A receive transfer ended with STOP |

## Verification
An SCL or SDA edge at the pins passes two synchronizer stages and one state register. Its effect on `sda_oe`, `addr_hit`, `byte_done`, `stop_seen` or `scl_oe` is therefore due three clock cycles later. `rx_full` and `rx_data` follow one cycle after that. A host strobe acts on the next cycle, and a waiting received byte reaches `rx_data` two cycles after `rx_rd`. The bench model of the master keeps each SCL half-period at 20 clock cycles. It samples every result 8 cycles after its own edge or strobe: always past the latency above, and always before the next bus edge could change the result.

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_rd,
  input  logic              clr_addr,
  input  logic              clr_stop,
  output logic              addr_hit,
  output logic              dir_tx,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              byte_done,
  output logic              stop_seen
);

  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [DATA_W-1:0] rsh, tsh, txd;
  logic [2:0]       scl_p, sda_p;
  logic             loaded, fresh, pending, mack;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire sda_h    = sda_p[1];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  assign scl_oe = (st == S_RX && cnt == '0 && (addr_hit || (pending && rx_full)))
               || (st == S_TX && cnt == '0 && (addr_hit || !loaded || fresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rsh       <= '0;
      tsh       <= '0;
      txd       <= '0;
      rx_data   <= '0;
      loaded    <= 1'b0;
      fresh     <= 1'b0;
      pending   <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      addr_hit  <= 1'b0;
      dir_tx    <= 1'b0;
      rx_full   <= 1'b0;
      tx_empty  <= 1'b1;
      byte_done <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (rx_rd) rx_full <= 1'b0;

      if (start_c) begin
        st      <= S_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        loaded  <= 1'b0;
        pending <= 1'b0;
      end else if (stop_c) begin
        if ((st == S_RX || st == S_RACK) && !dir_tx) stop_seen <= 1'b1;
        st      <= S_IDLE;
        sda_oe  <= 1'b0;
        loaded  <= 1'b0;
        pending <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              rsh <= {rsh[DATA_W-2:0], sda_h};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (rsh[DATA_W-1:1] == own_addr) begin
                st       <= S_AACK;
                sda_oe   <= 1'b1;
                addr_hit <= 1'b1;
                dir_tx   <= rsh[0];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              loaded <= 1'b0;
              st     <= dir_tx ? S_TX : S_RX;
            end
          end
          S_RX: begin
            if (scl_rise) begin
              rsh <= {rsh[DATA_W-2:0], sda_h};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              sda_oe <= 1'b1;
              st     <= S_RACK;
            end else if (pending) begin
              if (!rx_full) begin
                rx_data <= rsh;
                rx_full <= 1'b1;
                pending <= 1'b0;
              end else begin
                byte_done <= 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              cnt     <= '0;
              pending <= 1'b1;
              st      <= S_RX;
            end
          end
          S_TX: begin
            if (!loaded) begin
              if (!tx_empty) begin
                tsh      <= txd;
                tx_empty <= 1'b1;
                loaded   <= 1'b1;
                fresh    <= 1'b1;
                sda_oe   <= ~txd[DATA_W-1];
              end
            end else if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= S_TACK;
              end else begin
                tsh    <= tsh << 1;
                sda_oe <= ~tsh[DATA_W-2];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              mack <= ~sda_h;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= S_TX;
                cnt    <= '0;
                loaded <= 1'b0;
                if (tx_empty) byte_done <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end

      if (clr_addr) addr_hit <= 1'b0;
      if (clr_stop) stop_seen <= 1'b0;
      if (rx_rd || tx_wr) byte_done <= 1'b0;
      if (tx_wr) begin
        txd      <= tx_data;
        tx_empty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              tx_wr,
  input logic              rx_rd,
  input logic              clr_addr,
  input logic              clr_stop,
  input logic [DATA_W-1:0] rx_data,
  input logic              addr_hit,
  input logic              dir_tx,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              byte_done,
  input logic              stop_seen
);

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R10

  AST_ADDR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_addr |=> !addr_hit); // R3

  AST_RX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data))); // R5

  AST_STALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd || tx_wr) |=> !byte_done); // R5

  AST_TX_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty); // R7

  AST_STOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stop |=> !stop_seen); // R9

  AST_STOP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> !dir_tx); // R9

endmodule

bind i2c_target i2c_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .tx_wr(tx_wr), .rx_rd(rx_rd), .clr_addr(clr_addr), .clr_stop(clr_stop),
  .rx_data(rx_data), .addr_hit(addr_hit), .dir_tx(dir_tx), .rx_full(rx_full),
  .tx_empty(tx_empty), .byte_done(byte_done), .stop_seen(stop_seen)
);

// File: tb/i2c_target_bench.sv
module i2c_target_bench;
  localparam int T = 20;
  localparam logic [6:0] OWN = 7'h48;
  localparam int NV = 5;
  localparam logic [16:0] VEC [NV] = '{
    {8'h90, 8'hA5, 1'b1},
    {8'h90, 8'h00, 1'b1},
    {8'h90, 8'hFF, 1'b1},
    {8'h92, 8'h3C, 1'b0},
    {8'h10, 8'h81, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0, clr_addr = 1'b0, clr_stop = 1'b0;
  logic scl_oe, sda_oe, addr_hit, dir_tx, rx_full, tx_empty, byte_done, stop_seen;
  logic [7:0] rx_data;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_target u_i2c_target (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_data(tx_data), .tx_wr(tx_wr),
    .rx_data(rx_data), .rx_rd(rx_rd), .clr_addr(clr_addr), .clr_stop(clr_stop),
    .addr_hit(addr_hit), .dir_tx(dir_tx), .rx_full(rx_full), .tx_empty(tx_empty),
    .byte_done(byte_done), .stop_seen(stop_seen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wt(T); scl_up(); wt(T); m_scl = 1'b0; wt(4);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wt(T); scl_up(); wt(T/2); b = sda_bus; wt(T/2); m_scl = 1'b0; wt(4);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wt(T); scl_up(); wt(T); m_sda = 1'b0; wt(T); m_scl = 1'b0; wt(4);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wt(T); scl_up(); wt(T); m_sda = 1'b1; wt(T);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack_it);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
    put_bit(~ack_it);
    m_sda = 1'b1;
  endtask

  task automatic host_wr(input logic [7:0] v);
    tx_data = v; tx_wr = 1'b1; wt(1); tx_wr = 1'b0;
  endtask
  task automatic host_rd(); rx_rd = 1'b1; wt(1); rx_rd = 1'b0; endtask
  task automatic host_ca(); clr_addr = 1'b1; wt(1); clr_addr = 1'b0; endtask
  task automatic host_cs(); clr_stop = 1'b1; wt(1); clr_stop = 1'b0; endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] v;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {addr_hit, rx_full, byte_done, stop_seen}, 0);
    chk("R1 tx_empty", tx_empty, 1);

    for (int i = 0; i < NV; i++) begin
      do_start();
      send_byte(VEC[i][16:9], ack);
      chk("R2 address ack", ack, VEC[i][0]);
      wt(8);
      chk("R3 addr_hit", addr_hit, VEC[i][0]);
      chk("R3 stretch after match", scl_oe, VEC[i][0]);
      if (VEC[i][0]) begin
        host_ca(); wt(8);
        chk("R3 release on clear", scl_oe, 0);
      end
      send_byte(VEC[i][8:1], ack);
      chk("R4 data ack", ack, VEC[i][0]);
      wt(8);
      chk("R4 rx_full", rx_full, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R4 rx_data", rx_data, VEC[i][8:1]);
        host_rd(); wt(8);
        chk("R4 rx_full cleared", rx_full, 0);
      end
      do_stop(); wt(8);
      chk("R9 stop_seen", stop_seen, VEC[i][0]);
      host_cs(); wt(4);
    end

    do_start();
    send_byte(8'h90, ack); wt(8); host_ca();
    send_byte(8'hA1, ack); wt(8);
    chk("R4 first byte ready", rx_full, 1);
    chk("R4 no stall yet", byte_done, 0);
    send_byte(8'hB2, ack);
    chk("R5 second byte acked", ack, 1);
    wt(8);
    chk("R5 byte_done", byte_done, 1);
    chk("R5 stretch while full", scl_oe, 1);
    chk("R5 old byte kept", rx_data, 8'hA1);
    host_rd(); wt(8);
    chk("R5 byte moved", rx_data, 8'hB2);
    chk("R5 rx_full again", rx_full, 1);
    chk("R5 stall cleared", byte_done, 0);
    chk("R5 scl released", scl_oe, 0);
    host_rd();

    send_byte(8'h11, ack); wt(8); host_rd();
    do_start();
    send_byte(8'h91, ack);
    chk("R11 repeated start ack", ack, 1);
    wt(8);
    chk("R11 addr_hit", addr_hit, 1);
    chk("R6 dir_tx", dir_tx, 1);
    chk("R3 stretch tx", scl_oe, 1);
    host_ca(); wt(8);
    chk("R7 stretch without data", scl_oe, 1);
    host_wr(8'hC3); wt(10);
    chk("R6 register moved", tx_empty, 1);
    chk("R6 released after load", scl_oe, 0);
    host_wr(8'h5A);
    recv_byte(v, 1'b1);
    chk("R6 first byte", v, 8'hC3);
    wt(8);
    chk("R6 no stall when prefilled", byte_done, 0);
    recv_byte(v, 1'b1);
    chk("R6 second byte", v, 8'h5A);
    wt(8);
    chk("R7 underrun stall", byte_done, 1);
    chk("R7 stretch on underrun", scl_oe, 1);
    host_wr(8'h0F); wt(8);
    chk("R7 stall cleared", byte_done, 0);
    recv_byte(v, 1'b0);
    chk("R7 new byte not repeat", v, 8'h0F);
    wt(8);
    chk("R8 sda released", sda_oe, 0);
    get_bit(ack);
    chk("R8 no drive after nack", ack, 1);
    do_stop(); wt(8);
    chk("R9 no stop flag after tx", stop_seen, 0);
    chk("R8 scl free", scl_oe, 0);

    finish_run();
  end
endmodule